// File: doc/BRIEF.md
# Ping-pong slot tracker for multi-channel buffer capture

The block keeps track of three producer channels. Each channel fills two memory buffers in turn. A producer marks the end of a buffer with a one-cycle completion pulse and presents a coarse and a fine timestamp at the same time. The block records which slot finished, latches that slot's timestamps and moves the channel over to its other buffer address. The address of the buffer now in use is driven out so that a transfer engine can follow it.

A processor works through a small word-addressed register bus. It reads the ready and error flags, clears them by writing ones, programs the six buffer addresses and a matrix length, and reads the latched timestamps. A level interrupt summarises the flags that are enabled. The memory transfers and the arithmetic on the buffers belong to other blocks, so the producers here are plain pulse inputs.

Register word indices: 0 configuration, 1 status, 2 matrix length, 3..8 buffer addresses, 9..14 coarse timestamps, 15..20 fine timestamps. Each group of six registers is ordered channel 0 slot 0, channel 0 slot 1, channel 1 slot 0, and so on.

Top module: `pingpong_slot_tracker`

## Requirements
- R1: After reset the status, configuration, buffer addresses and timestamp registers read 0, every channel points at slot 0, irq is 0 and the matrix length reads 200.
- R2: A completion pulse on channel c sets status bit 2c+p, where p is the channel's current slot, and then toggles p. activeAddr field c shows the address register of the slot now in use (index 3+2c+p).
- R3: When a completion sets a ready bit, coarseIn and fineIn of that channel are latched into the coarse (index 9+2c+p) and fine (index 15+2c+p) registers of that slot.
- R4: A completion on a slot whose ready bit is still set sets status bit 7 (buffer full). The slot's latched timestamps stay unchanged, and the slot pointer still toggles.
- R5: A pulse on fifoErrIn[c] sets status bit 8+c.
- R6: Writing the status register clears every bit written as 1. A flag set in the same cycle stays set. Bit 6 and bits 31..11 always read 0.
- R7: hkField always equals status bits 10..7.
- R8: irq is 1 exactly when a ready bit (bits 5..0) is set while configuration bit 0 is 1, or an error bit (bits 10..7) is set while configuration bit 1 is 1.
- R9: The buffer address registers and the matrix length register (16 bits) read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word index |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| doneIn | input | 3 | Per-channel buffer completion pulse |
| coarseIn | input | 96 | Per-channel coarse time, channel c in bits 32c+31..32c |
| fineIn | input | 48 | Per-channel fine time, channel c in bits 16c+15..16c |
| fifoErrIn | input | 3 | Per-channel input FIFO write error pulse |
| activeAddr | output | 96 | Per-channel address of the buffer in use |
| irq | output | 1 | Level interrupt |
| hkField | output | 4 | Error flags for housekeeping (status bits 10..7) |

## Verification
On every cycle the assertions check four things. A status write leaves no written-one bit set unless a new event arrived in that cycle. A completion always leaves a ready flag set for its channel. A completion while both slots are full raises buffer-full. Timestamps are latched only into a slot that was free. They also hold irq to a nonzero status and keep the read-back of hkField, the reserved bits and the ready bits consistent. Only the bench scenarios can show the exact slot order, which timestamp value lands in which register, that an overrun leaves old timestamps untouched, and which address a channel uses after several completions.

// File: rtl/ppst_pkg.sv
package ppst_pkg;
  localparam int NCH       = 3;
  localparam int NSLOT     = 2 * NCH;
  localparam int STAT_W    = 11;
  localparam int REG_AW    = 5;
  localparam int FULL_BIT  = 7;
  localparam int FIFO_LSB  = 8;
  localparam int ERR_W     = STAT_W - FULL_BIT;
  localparam logic [STAT_W-1:0] STAT_MASK = 11'h7BF;

  localparam int REG_CFG    = 0;
  localparam int REG_STATUS = 1;
  localparam int REG_LEN    = 2;
  localparam int REG_ADDR0  = 3;
  localparam int REG_CT0    = REG_ADDR0 + NSLOT;
  localparam int REG_FT0    = REG_CT0 + NSLOT;

  typedef struct packed {
    logic [NSLOT-1:0] latchTs;
    logic [NSLOT-1:0] addrWe;
    logic             lenWe;
  } dpStrobe_t;
endpackage

// File: rtl/ppst_ctrl.sv
module ppst_ctrl
  import ppst_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWe,
  input  logic [REG_AW-1:0]      regAddr,
  input  logic [STAT_W-1:0]      regWdataLo,
  input  logic [NCH-1:0]         doneIn,
  input  logic [NCH-1:0]         fifoErrIn,
  output logic [STAT_W-1:0]      statusQ,
  output logic [1:0]             cfgQ,
  output logic [NCH-1:0]         slotPtr,
  output dpStrobe_t              strobe,
  output logic                   irq,
  output logic [ERR_W-1:0]       hkField
);
  logic [STAT_W-1:0] setBits;
  logic [STAT_W-1:0] clrMask;
  logic [STAT_W-1:0] statusNext;
  logic              statusWr;
  logic              cfgWr;

  assign statusWr = regWe && (regAddr == REG_AW'(REG_STATUS));
  assign cfgWr    = regWe && (regAddr == REG_AW'(REG_CFG));
  assign clrMask  = statusWr ? regWdataLo : '0;

  // completion and error events to flag set requests and latch strobes
  always_comb begin
    setBits        = '0;
    strobe.latchTs = '0;
    for (int c = 0; c < NCH; c++) begin
      if (doneIn[c]) begin
        if (statusQ[2*c + int'(slotPtr[c])]) begin
          setBits[FULL_BIT] = 1'b1;
        end else begin
          setBits[2*c + int'(slotPtr[c])]        = 1'b1;
          strobe.latchTs[2*c + int'(slotPtr[c])] = 1'b1;
        end
      end
      setBits[FIFO_LSB + c] = fifoErrIn[c];
    end
  end

  always_comb begin
    for (int s = 0; s < NSLOT; s++) begin
      strobe.addrWe[s] = regWe && (regAddr == REG_AW'(REG_ADDR0 + s));
    end
    strobe.lenWe = regWe && (regAddr == REG_AW'(REG_LEN));
  end

  assign statusNext = ((statusQ & ~clrMask) | setBits) & STAT_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      cfgQ    <= '0;
    end else begin
      statusQ <= statusNext;
      if (cfgWr) cfgQ <= regWdataLo[1:0];
    end
  end

  // one slot pointer per channel
  for (genvar c = 0; c < NCH; c++) begin : gPtr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          slotPtr[c] <= 1'b0;
      else if (doneIn[c]) slotPtr[c] <= ~slotPtr[c];
    end
  end

  assign hkField = statusQ[STAT_W-1:FULL_BIT];
  assign irq = (cfgQ[0] && (|statusQ[NSLOT-1:0])) ||
               (cfgQ[1] && (|statusQ[STAT_W-1:FULL_BIT]));
endmodule

// File: rtl/ppst_datapath.sv
module ppst_datapath
  import ppst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CT_W   = 32,
  parameter int FT_W   = 16,
  parameter int LEN_W  = 16,
  parameter int LEN_RESET = 200
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [REG_AW-1:0]      regAddr,
  input  logic [DATA_W-1:0]      regWdata,
  input  logic [NCH*CT_W-1:0]    coarseIn,
  input  logic [NCH*FT_W-1:0]    fineIn,
  input  logic [STAT_W-1:0]      statusQ,
  input  logic [1:0]             cfgQ,
  input  logic [NCH-1:0]         slotPtr,
  output logic [DATA_W-1:0]      regRdata,
  output logic [NCH*ADDR_W-1:0]  activeAddr
);
  logic [ADDR_W-1:0] addrQ [NSLOT];
  logic [CT_W-1:0]   ctQ   [NSLOT];
  logic [FT_W-1:0]   ftQ   [NSLOT];
  logic [LEN_W-1:0]  lenQ;

  for (genvar s = 0; s < NSLOT; s++) begin : gSlot
    localparam int CH = s / 2;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        addrQ[s] <= '0;
        ctQ[s]   <= '0;
        ftQ[s]   <= '0;
      end else begin
        if (strobe.addrWe[s]) addrQ[s] <= regWdata[ADDR_W-1:0];
        if (strobe.latchTs[s]) begin
          ctQ[s] <= coarseIn[CH*CT_W +: CT_W];
          ftQ[s] <= fineIn[CH*FT_W +: FT_W];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lenQ <= LEN_W'(LEN_RESET);
    else if (strobe.lenWe) lenQ <= regWdata[LEN_W-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : gAct
    assign activeAddr[c*ADDR_W +: ADDR_W] = slotPtr[c] ? addrQ[2*c+1] : addrQ[2*c];
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == REG_AW'(REG_CFG))    regRdata[1:0] = cfgQ;
    if (regAddr == REG_AW'(REG_STATUS)) regRdata[STAT_W-1:0] = statusQ;
    if (regAddr == REG_AW'(REG_LEN))    regRdata[LEN_W-1:0] = lenQ;
    for (int s = 0; s < NSLOT; s++) begin
      if (regAddr == REG_AW'(REG_ADDR0 + s)) regRdata[ADDR_W-1:0] = addrQ[s];
      if (regAddr == REG_AW'(REG_CT0 + s))   regRdata[CT_W-1:0]   = ctQ[s];
      if (regAddr == REG_AW'(REG_FT0 + s))   regRdata[FT_W-1:0]   = ftQ[s];
    end
  end
endmodule

// File: rtl/pingpong_slot_tracker.sv
module pingpong_slot_tracker
  import ppst_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CT_W   = 32,
  parameter int FT_W   = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWe,
  input  logic [REG_AW-1:0]     regAddr,
  input  logic [DATA_W-1:0]     regWdata,
  output logic [DATA_W-1:0]     regRdata,
  input  logic [NCH-1:0]        doneIn,
  input  logic [NCH*CT_W-1:0]   coarseIn,
  input  logic [NCH*FT_W-1:0]   fineIn,
  input  logic [NCH-1:0]        fifoErrIn,
  output logic [NCH*ADDR_W-1:0] activeAddr,
  output logic                  irq,
  output logic [ERR_W-1:0]      hkField
);
  logic [STAT_W-1:0] statusQ;
  logic [1:0]        cfgQ;
  logic [NCH-1:0]    slotPtr;
  dpStrobe_t         strobe;

  ppst_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdataLo(regWdata[STAT_W-1:0]), .doneIn(doneIn), .fifoErrIn(fifoErrIn),
    .statusQ(statusQ), .cfgQ(cfgQ), .slotPtr(slotPtr), .strobe(strobe),
    .irq(irq), .hkField(hkField)
  );

  ppst_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CT_W(CT_W), .FT_W(FT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr), .regWdata(regWdata),
    .coarseIn(coarseIn), .fineIn(fineIn), .statusQ(statusQ), .cfgQ(cfgQ),
    .slotPtr(slotPtr), .regRdata(regRdata), .activeAddr(activeAddr)
  );
endmodule

// File: rtl/ppst_chk.sv
module ppst_chk
  import ppst_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [REG_AW-1:0] regAddr,
  input logic [STAT_W-1:0] regWdataLo,
  input logic [DATA_W-1:0] regRdata,
  input logic [NCH-1:0]    doneIn,
  input logic [NCH-1:0]    fifoErrIn,
  input logic              irq,
  input logic [ERR_W-1:0]  hkField,
  input logic [STAT_W-1:0] statusQ,
  input dpStrobe_t         strobe
);
  // R6
  status_w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == REG_AW'(REG_STATUS) && doneIn == '0 && fifoErrIn == '0)
    |=> ((statusQ & $past(regWdataLo)) == '0));

  // R6
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_AW'(REG_STATUS)) |-> (regRdata[DATA_W-1:STAT_W] == '0 && regRdata[6] == 1'b0));

  // R7
  hk_mirror_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_AW'(REG_STATUS)) |-> (hkField == regRdata[STAT_W-1:FULL_BIT]));

  // R2
  ready_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == REG_AW'(REG_STATUS)) |-> (regRdata[NSLOT-1:0] == statusQ[NSLOT-1:0]));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusQ != '0));

  for (genvar c = 0; c < NCH; c++) begin : gCh
    // R2
    ready_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
      (doneIn[c] && !regWe) |=> (statusQ[2*c] || statusQ[2*c+1]));
    // R4
    overrun_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
      (doneIn[c] && statusQ[2*c] && statusQ[2*c+1] && !regWe) |=> statusQ[FULL_BIT]);
  end

  for (genvar s = 0; s < NSLOT; s++) begin : gSl
    // R4
    latch_free_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.latchTs[s] |-> !statusQ[s]);
  end
endmodule

bind pingpong_slot_tracker ppst_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdataLo(regWdata[ppst_pkg::STAT_W-1:0]), .regRdata(regRdata),
  .doneIn(doneIn), .fifoErrIn(fifoErrIn), .irq(irq), .hkField(hkField),
  .statusQ(statusQ), .strobe(strobe)
);

// File: tb/tb_pingpong_slot_tracker.sv
module tb_pingpong_slot_tracker;
  localparam int NCH = 3;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_DONE = 2'd2, OP_FERR = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{OP_WR, 5'd3, 32'h1000, 32'h0, 8'd9},
    '{OP_WR, 5'd4, 32'h2000, 32'h0, 8'd9},
    '{OP_WR, 5'd5, 32'h3000, 32'h0, 8'd9},
    '{OP_WR, 5'd6, 32'h4000, 32'h0, 8'd9},
    '{OP_WR, 5'd7, 32'h5000, 32'h0, 8'd9},
    '{OP_WR, 5'd8, 32'h6000, 32'h0, 8'd9},
    '{OP_RD, 5'd3, 32'h0, 32'h1000, 8'd9},   // R9 address readback
    '{OP_RD, 5'd8, 32'h0, 32'h6000, 8'd9},   // R9
    '{OP_RD, 5'd2, 32'h0, 32'd200, 8'd1},    // R1 length reset
    '{OP_RD, 5'd1, 32'h0, 32'h0, 8'd1},      // R1 status reset
    '{OP_DONE, 5'd0, 32'h100, 32'h1, 8'd2},
    '{OP_RD, 5'd1, 32'h0, 32'h1, 8'd2},      // R2 ch0 slot0
    '{OP_RD, 5'd9, 32'h0, 32'h100, 8'd3},    // R3 coarse ch0 s0
    '{OP_RD, 5'd15, 32'h0, 32'h100, 8'd3},   // R3 fine ch0 s0
    '{OP_DONE, 5'd0, 32'h200, 32'h7, 8'd2},
    '{OP_RD, 5'd1, 32'h0, 32'h17, 8'd2},     // R2 ch0 s1, ch1 s0, ch2 s0
    '{OP_RD, 5'd10, 32'h0, 32'h200, 8'd3},   // R3
    '{OP_RD, 5'd11, 32'h0, 32'h201, 8'd3},   // R3
    '{OP_RD, 5'd19, 32'h0, 32'h202, 8'd3},   // R3 fine ch2 s0
    '{OP_DONE, 5'd0, 32'h300, 32'h1, 8'd4},
    '{OP_RD, 5'd1, 32'h0, 32'h97, 8'd4},     // R4 buffer full
    '{OP_RD, 5'd9, 32'h0, 32'h100, 8'd4},    // R4 coarse kept
    '{OP_RD, 5'd15, 32'h0, 32'h100, 8'd4},   // R4 fine kept
    '{OP_WR, 5'd1, 32'h1, 32'h0, 8'd6},
    '{OP_RD, 5'd1, 32'h0, 32'h96, 8'd6},     // R6 single clear
    '{OP_WR, 5'd1, 32'hFFFF_FFFF, 32'h0, 8'd6},
    '{OP_RD, 5'd1, 32'h0, 32'h0, 8'd6},      // R6 clear all
    '{OP_FERR, 5'd0, 32'h5, 32'h5, 8'd5},
    '{OP_RD, 5'd1, 32'h0, 32'h500, 8'd5},    // R5 bits 8 and 10
    '{OP_WR, 5'd1, 32'h100, 32'h0, 8'd6},
    '{OP_RD, 5'd1, 32'h0, 32'h400, 8'd6},    // R6
    '{OP_WR, 5'd1, 32'h7FF, 32'h0, 8'd6},
    '{OP_WR, 5'd2, 32'h40, 32'h0, 8'd9},
    '{OP_RD, 5'd2, 32'h0, 32'h40, 8'd9},     // R9 length
    '{OP_RD, 5'd0, 32'h0, 32'h0, 8'd1}       // R1 config reset
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [4:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [NCH-1:0] doneIn = '0;
  logic [NCH*32-1:0] coarseIn = '0;
  logic [NCH*16-1:0] fineIn = '0;
  logic [NCH-1:0] fifoErrIn = '0;
  logic [NCH*32-1:0] activeAddr;
  logic irq;
  logic [3:0] hkField;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pingpong_slot_tracker dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .doneIn(doneIn), .coarseIn(coarseIn), .fineIn(fineIn),
    .fifoErrIn(fifoErrIn), .activeAddr(activeAddr), .irq(irq), .hkField(hkField)
  );

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic pulse(input logic [NCH-1:0] m, input logic [31:0] base);
    @(negedge clk);
    doneIn = m;
    for (int c = 0; c < NCH; c++) begin
      coarseIn[c*32 +: 32] = base + 32'(c);
      fineIn[c*16 +: 16]   = base[15:0] + 16'(c);
    end
    @(negedge clk);
    doneIn = '0;
  endtask

  task automatic ferr(input logic [NCH-1:0] m);
    @(negedge clk);
    fifoErrIn = m;
    @(negedge clk);
    fifoErrIn = '0;
  endtask

  task automatic rdChk(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    check(tag, 128'(regRdata), 128'(exp));
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state at the ports
    #1;
    check("R1 irq", 128'(irq), 128'(0));
    check("R1 hkField", 128'(hkField), 128'(0));
    check("R1 activeAddr", 128'(activeAddr), 128'(0));

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_WR:   wrReg(VECS[i].addr, VECS[i].data);
        OP_RD:   rdChk(VECS[i].addr, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
        OP_DONE: pulse(VECS[i].exp[NCH-1:0], VECS[i].data);
        default: ferr(VECS[i].exp[NCH-1:0]);
      endcase
    end

    // R2 pointers: ch0 toggled 3 times, ch1 and ch2 once each
    #1;
    check("R2 activeAddr", 128'(activeAddr), 128'({32'h6000, 32'h4000, 32'h2000}));

    // R7 housekeeping field, R8 error enable
    ferr(3'b101);
    #1;
    check("R7 hkField", 128'(hkField), 128'(4'hA));
    check("R8 irq disabled", 128'(irq), 128'(0));
    wrReg(5'd0, 32'h2);
    #1;
    check("R8 irq error", 128'(irq), 128'(1));
    wrReg(5'd1, 32'h7FF);
    #1;
    check("R8 irq cleared", 128'(irq), 128'(0));

    // R8 ready enable; ch1 is on slot 1 -> bit 3
    wrReg(5'd0, 32'h1);
    pulse(3'b010, 32'h400);
    #1;
    check("R8 irq ready", 128'(irq), 128'(1));
    check("R2 ch1 back to slot0", 128'(activeAddr[63:32]), 128'(32'h3000));
    wrReg(5'd0, 32'h2);
    #1;
    check("R8 ready not enabled", 128'(irq), 128'(0));
    rdChk(5'd1, 32'h8, "R2 ch1 slot1");
    rdChk(5'd12, 32'h401, "R3 coarse ch1 s1");

    // R6 set wins over a clear in the same cycle; ch2 on slot 1 -> bit 5
    @(negedge clk);
    regWe = 1'b1; regAddr = 5'd1; regWdata = 32'h7FF;
    doneIn = 3'b100;
    coarseIn[95:64] = 32'h500; fineIn[47:32] = 16'h500;
    @(negedge clk);
    regWe = 1'b0; doneIn = '0;
    rdChk(5'd1, 32'h20, "R6 set beats clear");
    rdChk(5'd14, 32'h500, "R3 coarse ch2 s1");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule